// File: doc/BRIEF.md
# Flash Security Unlock Controller

This block decides whether an on-chip flash memory is locked, and it re-decides this after every reset. After reset it loads a two-bit security field from non-volatile storage. Two independent paths can then lift the lock. In normal operation, software can present a four-word backdoor key. A correct key lifts the lock only until the next reset; the controller has no path that writes storage back. In special mode, the controller reads every word of the array right after reset while it holds the CPU. If the whole array reads as erased, it raises a status bit that overrides the lock.

The block also runs a simple command engine for program and full-erase requests, which are gated by a protection bit. The engine keeps two completion flags: buffers-empty and all-commands-done. A local enable and a global mask gate each flag into an interrupt request. A reset during a command drops the command before its result is committed to the array.

Register map on `reg_addr` (16-bit data): 0 config (bit0 buffers-empty IRQ enable, bit1 command-done IRQ enable, bit2 key path enable), 1 protection (bit0, 1 = protected, reset 1), 2 status (read only: bit0 buffers-empty, bit1 command-done, bit2 locked, bit3 blank-verified, bit4 key path blocked), 3 address buffer, 4 data buffer, 5 command (0x41 full erase, 0x20 program word), 6 key compare trigger, 8..11 key words 0..3.

Top module: `flash_sec_ctrl`

## Requirements
- R1: A few cycles after reset is released, `secured` reads 1 unless the stored field `sec_field` equals 2'b10. Every unlock from before the reset is discarded.
- R2: Writing key words (offsets 8..11) and then the trigger (offset 6) with the key path enabled clears `secured` until the next reset. This requires all four words to equal the matching 16-bit slices of `key_store`, with word i at bits [16i+15:16i], and no word may be 16'h0000 or 16'hFFFF.
- R3: A key unlock leaves the protection register readback unchanged.
- R4: While `special_mode` and `dbg_active` are both 1, key word writes and the trigger are ignored: no unlock and no block.
- R5: A failed comparison sets status bit4, and every later key attempt is ignored until reset.
- R6: In special mode, the array is scanned one word per cycle after reset while `hold_cpu` is 1. If every word is 16'hFFFF, status bit3 sets and `secured` clears. The scan stops at the first non-erased word and leaves bit3 at 0.
- R7: Writes to the protection register take effect only while `special_mode` and `dbg_active` are both 1. Commands issued while protection is 1 are dropped without a commit.
- R8: An accepted command clears command-done for CMD_CYCLES cycles. Command-done then sets, and `commit` pulses for one cycle with the operation, address and data.
- R9: A reset during a command aborts it: no commit occurs and command-done reads 1 after reset.
- R10: Buffers-empty clears on an address or data buffer write and sets again when a command write is taken. `irq_cbe` equals buffers-empty AND its enable AND NOT `irq_gmask`.
- R11: `irq_cc` equals command-done AND its enable AND NOT `irq_gmask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | Device in special mode |
| dbg_active | input | 1 | Debug interface in use |
| sec_field | input | 2 | Stored security field |
| key_store | input | 64 | Stored backdoor key, word i at bits [16i+15:16i] |
| irq_gmask | input | 1 | Global interrupt mask |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| arr_addr | output | ADDR_W | Array read address for the blank scan |
| arr_rdata | input | 16 | Array read data |
| commit | output | 1 | One-cycle pulse when a command completes |
| commit_erase | output | 1 | Completed command is a full erase (else program) |
| commit_addr | output | ADDR_W | Program address |
| commit_data | output | 16 | Program data |
| hold_cpu | output | 1 | CPU held during the post-reset sequence |
| secured | output | 1 | Flash locked |
| irq_cbe | output | 1 | Buffers-empty interrupt request |
| irq_cc | output | 1 | Command-done interrupt request |

## Verification
A stale unlock flag shows on `secured` and status bit2 on the first read after the reset sequence, so the bench checks status after every reset against the stored field. A comparator that accepts a wrong or degenerate key, or that fails to block, shows up at once on the status read after the trigger. A later correct key also exposes a block that is missing. A wrong scan shows as a wrong bit3 once the window for a full scan has passed. A command engine that commits too early, or commits after an abort, changes the array model kept by the bench, and the bench reads that model back through later scans.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam logic [3:0] REG_CFG  = 4'd0;
  localparam logic [3:0] REG_PROT = 4'd1;
  localparam logic [3:0] REG_STAT = 4'd2;
  localparam logic [3:0] REG_ADDR = 4'd3;
  localparam logic [3:0] REG_DATA = 4'd4;
  localparam logic [3:0] REG_CMD  = 4'd5;
  localparam logic [3:0] REG_KGO  = 4'd6;

  localparam logic [7:0] CMD_ERASE = 8'h41;
  localparam logic [7:0] CMD_PROG  = 8'h20;
  localparam logic [1:0] SEC_OPEN  = 2'b10;

  typedef enum logic [2:0] {SC_START, SC_SCAN, SC_PASS, SC_FAIL, SC_OFF} scan_state_e;
  typedef enum logic [1:0] {OP_NONE, OP_ERASE, OP_PROG} cmd_op_e;
endpackage

// File: rtl/fsc_key_cmp.sv
module fsc_key_cmp #(
  parameter int KEY_WORDS = 4,
  parameter int WORD_W    = 16
) (
  input  logic [KEY_WORDS*WORD_W-1:0] entered_i,
  input  logic [KEY_WORDS*WORD_W-1:0] stored_i,
  output logic                        match_o
);
  logic [KEY_WORDS-1:0] eq;
  logic [KEY_WORDS-1:0] degen;

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
    assign eq[g]    = (entered_i[g*WORD_W +: WORD_W] == stored_i[g*WORD_W +: WORD_W]);
    assign degen[g] = (&entered_i[g*WORD_W +: WORD_W]) | ~(|entered_i[g*WORD_W +: WORD_W]);
  end

  assign match_o = (&eq) & ~(|degen);
endmodule

// File: rtl/fsc_blank_scan.sv
module fsc_blank_scan
  import fsc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              hold_o,
  output logic              unsec_o
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  scan_state_e       state_q, state_d;
  logic [ADDR_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      SC_START: begin
        idx_d   = '0;
        state_d = special_i ? SC_SCAN : SC_OFF;
      end
      SC_SCAN: begin
        if (rd_data_i != {DATA_W{1'b1}}) state_d = SC_FAIL;
        else if (idx_q == LAST)          state_d = SC_PASS;
        else                             idx_d   = idx_q + 1'b1;
      end
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_START;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign rd_addr_o = idx_q;
  assign hold_o    = (state_q == SC_START) || (state_q == SC_SCAN);
  assign unsec_o   = (state_q == SC_PASS);

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n) (state_q == SC_SCAN && idx_q != '0) |-> ($past(state_q) == SC_SCAN && idx_q == ADDR_W'($past(idx_q) + 1'b1))); // R6
  AST_PASS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (state_q == SC_PASS) |=> (state_q == SC_PASS)); // R6
  AST_FAIL_NOPASS: assert property (@(posedge clk) disable iff (!rst_n) (state_q == SC_FAIL) |=> !unsec_o); // R6
endmodule

// File: rtl/fsc_irq.sv
module fsc_irq (
  input  logic cbe_flag_i,
  input  logic cc_flag_i,
  input  logic cbe_en_i,
  input  logic cc_en_i,
  input  logic gmask_i,
  output logic irq_cbe_o,
  output logic irq_cc_o
);
  assign irq_cbe_o = cbe_flag_i & cbe_en_i & ~gmask_i;
  assign irq_cc_o  = cc_flag_i & cc_en_i & ~gmask_i;
endmodule

// File: rtl/flash_sec_ctrl.sv
module flash_sec_ctrl
  import fsc_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int KEY_WORDS  = 4,
  parameter int CMD_CYCLES = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        special_mode,
  input  logic                        dbg_active,
  input  logic [1:0]                  sec_field,
  input  logic [KEY_WORDS*DATA_W-1:0] key_store,
  input  logic                        irq_gmask,
  input  logic                        reg_wr,
  input  logic [3:0]                  reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  output logic [ADDR_W-1:0]           arr_addr,
  input  logic [DATA_W-1:0]           arr_rdata,
  output logic                        commit,
  output logic                        commit_erase,
  output logic [ADDR_W-1:0]           commit_addr,
  output logic [DATA_W-1:0]           commit_data,
  output logic                        hold_cpu,
  output logic                        secured,
  output logic                        irq_cbe,
  output logic                        irq_cc
);
  localparam int KEY_BITS = KEY_WORDS * DATA_W;
  localparam int CNT_W    = $clog2(CMD_CYCLES + 1);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic                load_q, load_d;
  logic                sec_ok_q, sec_ok_d;
  logic                kun_q, kun_d;
  logic                klock_q, klock_d;
  logic [KEY_BITS-1:0] kbuf_q, kbuf_d;
  logic [2:0]          cfg_q, cfg_d;
  logic                prot_q, prot_d;
  logic                cbeif_q, cbeif_d;
  logic                ccif_q, ccif_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0]   data_q, data_d;
  cmd_op_e             op_q, op_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                commit_q, commit_d;

  logic scan_hold, scan_unsec, key_match;
  logic dbg_side, key_path_ok, key_word_sel, cmd_known;

  fsc_blank_scan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_s),
    .special_i (special_mode),
    .rd_addr_o (arr_addr),
    .rd_data_i (arr_rdata),
    .hold_o    (scan_hold),
    .unsec_o   (scan_unsec)
  );

  fsc_key_cmp #(.KEY_WORDS(KEY_WORDS), .WORD_W(DATA_W)) u_key (
    .entered_i (kbuf_q),
    .stored_i  (key_store),
    .match_o   (key_match)
  );

  fsc_irq u_irq (
    .cbe_flag_i (cbeif_q),
    .cc_flag_i  (ccif_q),
    .cbe_en_i   (cfg_q[0]),
    .cc_en_i    (cfg_q[1]),
    .gmask_i    (irq_gmask),
    .irq_cbe_o  (irq_cbe),
    .irq_cc_o   (irq_cc)
  );

  assign dbg_side     = special_mode & dbg_active;
  assign key_path_ok  = cfg_q[2] & ~dbg_side & ~klock_q;
  assign key_word_sel = reg_addr[3] & ({1'b0, reg_addr[2:0]} < 4'(KEY_WORDS));
  assign cmd_known    = (reg_wdata[7:0] == CMD_ERASE) || (reg_wdata[7:0] == CMD_PROG);

  always_comb begin
    load_d   = 1'b0;
    sec_ok_d = sec_ok_q;
    kun_d    = kun_q;
    klock_d  = klock_q;
    kbuf_d   = kbuf_q;
    cfg_d    = cfg_q;
    prot_d   = prot_q;
    cbeif_d  = cbeif_q;
    ccif_d   = ccif_q;
    addr_d   = addr_q;
    data_d   = data_q;
    op_d     = op_q;
    cnt_d    = cnt_q;
    commit_d = 1'b0;

    if (load_q) sec_ok_d = (sec_field == SEC_OPEN);

    if (reg_wr) begin
      case (reg_addr)
        REG_CFG:  cfg_d = reg_wdata[2:0];
        REG_PROT: if (dbg_side) prot_d = reg_wdata[0];
        REG_ADDR: if (ccif_q) begin
          addr_d  = reg_wdata[ADDR_W-1:0];
          cbeif_d = 1'b0;
        end
        REG_DATA: if (ccif_q) begin
          data_d  = reg_wdata;
          cbeif_d = 1'b0;
        end
        REG_CMD: if (ccif_q && !scan_hold) begin
          cbeif_d = 1'b1;
          if (cmd_known && !prot_q) begin
            ccif_d = 1'b0;
            op_d   = (reg_wdata[7:0] == CMD_ERASE) ? OP_ERASE : OP_PROG;
            cnt_d  = CNT_W'(CMD_CYCLES - 1);
          end
        end
        REG_KGO: if (key_path_ok) begin
          if (key_match) kun_d   = 1'b1;
          else           klock_d = 1'b1;
        end
        default: if (key_word_sel && key_path_ok) begin
          for (int k = 0; k < KEY_WORDS; k++) begin
            if (reg_addr[2:0] == 3'(k)) kbuf_d[k*DATA_W +: DATA_W] = reg_wdata;
          end
        end
      endcase
    end

    if (!ccif_q) begin
      if (cnt_q == '0) begin
        ccif_d   = 1'b1;
        commit_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      load_q   <= 1'b1;
      sec_ok_q <= 1'b0;
      kun_q    <= 1'b0;
      klock_q  <= 1'b0;
      kbuf_q   <= '0;
      cfg_q    <= '0;
      prot_q   <= 1'b1;
      cbeif_q  <= 1'b1;
      ccif_q   <= 1'b1;
      addr_q   <= '0;
      data_q   <= '0;
      op_q     <= OP_NONE;
      cnt_q    <= '0;
      commit_q <= 1'b0;
    end else begin
      load_q   <= load_d;
      sec_ok_q <= sec_ok_d;
      kun_q    <= kun_d;
      klock_q  <= klock_d;
      kbuf_q   <= kbuf_d;
      cfg_q    <= cfg_d;
      prot_q   <= prot_d;
      cbeif_q  <= cbeif_d;
      ccif_q   <= ccif_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
      op_q     <= op_d;
      cnt_q    <= cnt_d;
      commit_q <= commit_d;
    end
  end

  assign secured      = ~(sec_ok_q | kun_q | scan_unsec);
  assign hold_cpu     = scan_hold;
  assign commit       = commit_q;
  assign commit_erase = (op_q == OP_ERASE);
  assign commit_addr  = addr_q;
  assign commit_data  = data_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CFG:  reg_rdata[2:0] = cfg_q;
      REG_PROT: reg_rdata[0]   = prot_q;
      REG_STAT: reg_rdata[4:0] = {klock_q, scan_unsec, secured, ccif_q, cbeif_q};
      REG_ADDR: reg_rdata[ADDR_W-1:0] = addr_q;
      REG_DATA: reg_rdata = data_q;
      default:  reg_rdata = '0;
    endcase
  end

  AST_KEY_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_s) klock_q |=> klock_q); // R5
  AST_KEY_NOT_IN_DBG: assert property (@(posedge clk) disable iff (!rst_s) $rose(kun_q) |-> !$past(special_mode && dbg_active)); // R4
  AST_KEY_KEEPS_PROT: assert property (@(posedge clk) disable iff (!rst_s) $rose(kun_q) |-> $stable(prot_q)); // R3
  AST_PROT_DBG_ONLY: assert property (@(posedge clk) disable iff (!rst_s) !$stable(prot_q) |-> $past(special_mode && dbg_active)); // R7
  AST_COMMIT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_s) commit_q |-> (ccif_q && $past(!ccif_q))); // R8
  AST_NO_CC_IRQ_BUSY: assert property (@(posedge clk) disable iff (!rst_s) !ccif_q |-> !irq_cc); // R11
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_s) irq_gmask |-> !(irq_cbe || irq_cc)); // R10
endmodule

// File: tb/flash_sec_ctrl_test.sv
module flash_sec_ctrl_test;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        special_mode = 1'b0;
  logic        dbg_active = 1'b0;
  logic [1:0]  sec_field = 2'b00;
  logic [63:0] key_store = {16'hC0DE, 16'h5A5A, 16'h0F1E, 16'h1234};
  logic        irq_gmask = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [ADDR_W-1:0] arr_addr;
  logic [15:0] arr_rdata;
  logic        commit, commit_erase, hold_cpu, secured, irq_cbe, irq_cc;
  logic [ADDR_W-1:0] commit_addr;
  logic [15:0] commit_data;

  logic [15:0] mem [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_sec_ctrl uut (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .dbg_active(dbg_active),
    .sec_field(sec_field), .key_store(key_store), .irq_gmask(irq_gmask),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata), .commit(commit), .commit_erase(commit_erase),
    .commit_addr(commit_addr), .commit_data(commit_data), .hold_cpu(hold_cpu),
    .secured(secured), .irq_cbe(irq_cbe), .irq_cc(irq_cc)
  );

  assign arr_rdata = mem[arr_addr];

  always @(posedge clk) begin
    if (commit) begin
      if (commit_erase) for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
      else mem[commit_addr] <= mem[commit_addr] & commit_data;
    end
  end

  function automatic bit exp_secured(input logic [1:0] f, input bit kun, input bit unsec);
    return !((f == 2'b10) || kun || unsec);
  endfunction

  function automatic bit exp_key_ok(input logic [63:0] ent, input logic [63:0] sto);
    bit ok = (ent == sto);
    for (int i = 0; i < 4; i++) begin
      if (ent[i*16 +: 16] == 16'hFFFF || ent[i*16 +: 16] == 16'h0000) ok = 0;
    end
    return ok;
  endfunction

  function automatic bit exp_irq(input bit flag, input bit en, input bit gm);
    return flag && en && !gm;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset(input bit sm, input bit dbg);
    @(negedge clk);
    rst_n = 1'b0; special_mode = sm; dbg_active = dbg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (DEPTH + 16) @(negedge clk);
  endtask

  task automatic enter_key(input logic [63:0] k);
    for (int i = 0; i < 4; i++) wr(4'(8 + i), k[i*16 +: 16]);
    wr(4'd6, 16'd0);
  endtask

  task automatic wait_done();
    logic [15:0] s;
    for (int i = 0; i < 40; i++) begin
      rd(4'd2, s);
      if (s[1]) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] s, p;
    logic [63:0] k;
    logic [1:0]  f;
    bit          en0, en1, gm;
    void'($urandom(32'h5EC0_0001));
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'hFFFF;
    mem[5] = 16'h0000;

    // reset state, normal mode
    do_reset(0, 0);
    rd(4'd2, s);
    chk(s[4:0] == 5'b00111, "R1", "status after reset", s[4:0], 5'b00111);
    chk(secured == 1'b1, "R1", "secured after reset", secured, 1);
    chk(hold_cpu == 1'b0, "R6", "no hold in normal mode", hold_cpu, 0);

    // R1: random stored field, reloaded on each reset
    for (int n = 0; n < 12; n++) begin
      f = 2'($urandom_range(0, 3));
      sec_field = f;
      do_reset(0, 0);
      chk(secured == exp_secured(f, 0, 0), "R1", "secured vs field", secured, exp_secured(f, 0, 0));
    end
    sec_field = 2'b00;

    // R2/R3: correct key unlocks, prot unchanged, reset forgets
    do_reset(0, 0);
    wr(4'd0, 16'h0004);
    rd(4'd1, p);
    enter_key(key_store);
    chk(secured == 1'b0, "R2", "key unlock", secured, 0);
    rd(4'd1, s);
    chk(s == p, "R3", "prot readback after key unlock", s, p);
    do_reset(0, 0);
    chk(secured == 1'b1, "R1", "unlock forgotten after reset", secured, 1);

    // R2/R5: random keys, some mutated
    for (int n = 0; n < 10; n++) begin
      k = key_store;
      if ($urandom_range(0, 1)) k[$urandom_range(0, 3)*16 +: 16] ^= 16'(1 << $urandom_range(0, 15));
      do_reset(0, 0);
      wr(4'd0, 16'h0004);
      enter_key(k);
      chk(secured == !exp_key_ok(k, key_store), "R2", "random key result", secured, !exp_key_ok(k, key_store));
      rd(4'd2, s);
      chk(s[4] == !exp_key_ok(k, key_store), "R5", "block bit after key", s[4], !exp_key_ok(k, key_store));
    end

    // R5: after failure a correct key is ignored
    do_reset(0, 0);
    wr(4'd0, 16'h0004);
    enter_key(key_store ^ 64'h1);
    enter_key(key_store);
    chk(secured == 1'b1, "R5", "correct key after failure", secured, 1);

    // R2: degenerate key rejected even when stored equals it
    key_store = {4{16'hFFFF}};
    do_reset(0, 0);
    wr(4'd0, 16'h0004);
    enter_key(key_store);
    chk(secured == 1'b1, "R2", "all-ones key rejected", secured, 1);
    key_store = {4{16'h0000}};
    do_reset(0, 0);
    wr(4'd0, 16'h0004);
    enter_key(key_store);
    chk(secured == 1'b1, "R2", "all-zeros key rejected", secured, 1);
    key_store = {16'hC0DE, 16'h5A5A, 16'h0F1E, 16'h1234};

    // R10/R11: interrupt gating, random
    do_reset(0, 0);
    for (int n = 0; n < 12; n++) begin
      en0 = 1'($urandom); en1 = 1'($urandom); gm = 1'($urandom);
      wr(4'd0, {13'd0, 1'b0, en1, en0});
      irq_gmask = gm;
      @(negedge clk);
      chk(irq_cbe == exp_irq(1, en0, gm), "R10", "irq_cbe idle", irq_cbe, exp_irq(1, en0, gm));
      chk(irq_cc == exp_irq(1, en1, gm), "R11", "irq_cc idle", irq_cc, exp_irq(1, en1, gm));
    end
    irq_gmask = 1'b0;
    wr(4'd0, 16'h0003);
    wr(4'd3, 16'h0002);
    rd(4'd2, s);
    chk(s[0] == 1'b0, "R10", "buffers-empty cleared", s[0], 0);
    chk(irq_cbe == 1'b0, "R10", "irq_cbe after buffer write", irq_cbe, 0);

    // R7: prot write ignored outside debug, command dropped
    wr(4'd1, 16'h0000);
    rd(4'd1, s);
    chk(s[0] == 1'b1, "R7", "prot write outside debug", s[0], 1);
    wr(4'd5, 16'h0041);
    rd(4'd2, s);
    chk(s[1:0] == 2'b11, "R7", "protected erase dropped", s[1:0], 2'b11);
    chk(mem[5] == 16'h0000, "R7", "array untouched", mem[5], 0);

    // R4: key ignored in special+debug, blank scan fails (word 5 not erased)
    do_reset(1, 1);
    rd(4'd2, s);
    chk(s[3] == 1'b0, "R6", "scan fail leaves bit3", s[3], 0);
    chk(secured == 1'b1, "R6", "secured after failed scan", secured, 1);
    wr(4'd0, 16'h0004);
    enter_key(key_store ^ 64'h1);
    rd(4'd2, s);
    chk(s[4] == 1'b0, "R4", "no block in debug", s[4], 0);
    enter_key(key_store);
    chk(secured == 1'b1, "R4", "no unlock in debug", secured, 1);

    // R9: reset mid-erase aborts
    wr(4'd1, 16'h0000);
    wr(4'd5, 16'h0041);
    chk(irq_cc == 1'b0, "R11", "irq_cc while busy", irq_cc, 0);
    repeat (2) @(negedge clk);
    do_reset(1, 1);
    rd(4'd2, s);
    chk(s[1] == 1'b1, "R9", "command-done after abort", s[1], 1);
    chk(mem[5] == 16'h0000 && s[3] == 1'b0, "R9", "no commit after abort", mem[5], 0);

    // R8: full erase timing
    wr(4'd1, 16'h0000);
    wr(4'd5, 16'h0041);
    rd(4'd2, s);
    chk(s[1:0] == 2'b01, "R8", "busy right after launch", s[1:0], 2'b01);
    repeat (3) @(negedge clk);
    rd(4'd2, s);
    chk(s[1] == 1'b0, "R8", "still busy mid-command", s[1], 0);
    repeat (6) @(negedge clk);
    rd(4'd2, s);
    chk(s[1] == 1'b1, "R8", "done after command", s[1], 1);
    chk(mem[5] == 16'hFFFF, "R8", "erase committed", mem[5], 16'hFFFF);

    // R6: blank scan passes, hold during scan
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(hold_cpu == 1'b1, "R6", "hold during scan", hold_cpu, 1);
    repeat (DEPTH + 8) @(negedge clk);
    chk(hold_cpu == 1'b0, "R6", "hold released", hold_cpu, 0);
    rd(4'd2, s);
    chk(s[3] == 1'b1 && secured == 1'b0, "R6", "blank verified unlocks", s[3], 1);

    // R8: program word
    wr(4'd1, 16'h0000);
    wr(4'd3, 16'h0003);
    wr(4'd4, 16'h00F0);
    wr(4'd5, 16'h0020);
    wait_done();
    repeat (2) @(negedge clk);
    chk(mem[3] == 16'h00F0, "R8", "program committed", mem[3], 16'h00F0);

    // R1: stored field now open, normal mode
    sec_field = 2'b10;
    do_reset(0, 0);
    chk(secured == 1'b0, "R1", "open field unlocks", secured, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule